// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synchronous static memory for cache-style use. Address, control and write data are captured on the rising clock edge. A read returns its word through a second register stage. A write is committed to the array on the edge after it is captured. The word is split into byte lanes of nine bits: eight data bits and one parity bit. Any subset of lanes can be written, either through a full-word write strobe or through a byte-write strobe combined with a write enable for each lane.

Three chip-select inputs allow several devices to share a data bus. Selection takes effect two clock edges after the chip selects are sampled, and release follows the same latency, so two devices never drive the bus together. The pad drivers are modelled as a data output plus a drive-enable output. An output enable gates that drive-enable without any clock. A sleep input stops new accesses, releases the outputs at once and keeps the stored data.

Top module: `pipe_sram`

## Requirements
- R1: A read sampled on edge k places the stored word on q_o after edge k+1, and drive_o is high from then until the next edge, provided oe_ni is low and sleep_i is low.
- R2: An access with gw_ni low writes all lanes of d_i to the addressed word. It produces no output drive.
- R3: With gw_ni high and bw_ni low, lane i (bits 9i+8 down to 9i) is written exactly when we_ni[i] is low. The other lanes keep their contents.
- R4: With gw_ni high, and either bw_ni high or every we_ni bit high, nothing is written. The access is a read.
- R5: The device is selected only when ce1_ni is low, ce2_i is high and ce3_ni is low. An access sampled while the device is not selected neither writes nor drives the output two edges later.
- R6: drive_o falls as soon as oe_ni goes high and rises again as soon as oe_ni goes low, with no clock edge in between.
- R7: While sleep_i is high, no access is accepted and drive_o is low immediately. The array contents survive the sleep period.
- R8: drive_o stays low in the cycle after a write has been sampled.
- R9: The parity bit of each lane (bit 8 of the lane) is stored and returned like the data bits.
- R10: After reset, drive_o is low until a selected read has passed through both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low (pipeline control only) |
| addr_i | input | ADDR_W | Word address |
| ce1_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce3_ni | input | 1 | Chip select, active low |
| gw_ni | input | 1 | Full-word write strobe, active low |
| bw_ni | input | 1 | Byte-write strobe, active low |
| we_ni | input | LANES | Per-lane write enable, active low, bit i for lane i |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down request, active high |
| d_i | input | LANES*LANE_W | Write data, lane i in bits 9i+8:9i |
| q_o | output | LANES*LANE_W | Read data from the output register |
| drive_o | output | 1 | High when the pads would drive q_o |

## Verification
Directed sequences write full words, then overwrite alternating lanes with the byte strobe. Reading the result back separates a correct lane decode from a full-word or inverted decode. An access with both strobes inactive must leave the word unchanged and still return it. Parity-heavy patterns show whether bit 8 of each lane survives. Writes attempted while deselected, and accesses made during sleep, show whether the select and sleep gating act on both the write path and the output drive. Random mixes of selects, strobes, lane enables, output enable and sleep then compare every cycle's drive state and read data against a model. Back-to-back write-then-read pairs in that mix expose a read stage that returns data one cycle early or late.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              gw_ni,
  input  logic              bw_ni,
  input  logic [LANES-1:0]  we_ni,
  input  logic              sleep_i,
  input  logic [DW-1:0]     d_i,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output logic [LANES-1:0]  s1_mask_o,
  output logic [DW-1:0]     s1_data_o
);
  logic             sel;
  logic             acc;
  logic [LANES-1:0] mask;
  op_e              op_d;

  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;
  assign acc = sel & ~sleep_i;

  // full-word strobe overrides the per-lane path
  always_comb begin
    if (!gw_ni)      mask = '1;
    else if (!bw_ni) mask = ~we_ni;
    else             mask = '0;
  end

  always_comb begin
    if (!acc)       op_d = OP_IDLE;
    else if (|mask) op_d = OP_WRITE;
    else            op_d = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_o   <= OP_IDLE;
      s1_mask_o <= '0;
    end else begin
      s1_op_o   <= op_d;
      s1_mask_o <= acc ? mask : '0;
    end
  end

  always_ff @(posedge clk_i) begin
    s1_addr_o <= addr_i;
    s1_data_o <= d_i;
  end

  AST_SLEEP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> s1_op_o == OP_IDLE); // R7
  AST_DESEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce1_ni || !ce2_i || ce3_ni) |=> s1_op_o == OP_IDLE); // R5
  AST_GW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gw_ni && acc) |=> (s1_op_o == OP_WRITE && &s1_mask_o)); // R2
  AST_BYTE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && !bw_ni && acc) |=> s1_mask_o == ~$past(we_ni)); // R3
  AST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && (bw_ni || &we_ni) && acc) |=> (s1_op_o == OP_READ && s1_mask_o == '0)); // R4
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_mask_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_mask_i[g]) mem[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = mem[rd_addr_i];
  end
endmodule

// File: rtl/sram_outreg.sv
module sram_outreg
  import sram_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           s1_op_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          oe_ni,
  input  logic          sleep_i,
  output logic [DW-1:0] q_o,
  output logic          drive_o
);
  logic drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= (s1_op_i == OP_READ);
  end

  always_ff @(posedge clk_i) begin
    if (s1_op_i == OP_READ) q_o <= rd_data_i;
  end

  // pad enable is combinational in oe_ni and sleep_i
  assign drive_o = drv_q & ~oe_ni & ~sleep_i;

  AST_RD_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_op_i == OP_READ) |=> drv_q); // R1
  AST_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_op_i == OP_WRITE) |=> !drive_o); // R8
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              gw_ni,
  input  logic              bw_ni,
  input  logic [LANES-1:0]  we_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  input  logic [DW-1:0]     d_i,
  output logic [DW-1:0]     q_o,
  output logic              drive_o
);
  op_e              s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [DW-1:0]     s1_data;
  logic [DW-1:0]     rd_data;

  sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_ctrl (
    .clk_i, .rst_ni, .addr_i, .ce1_ni, .ce2_i, .ce3_ni,
    .gw_ni, .bw_ni, .we_ni, .sleep_i, .d_i,
    .s1_op_o(s1_op), .s1_addr_o(s1_addr), .s1_mask_o(s1_mask), .s1_data_o(s1_data)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk_i,
    .wr_en_i(s1_op == OP_WRITE),
    .wr_addr_i(s1_addr),
    .wr_mask_i(s1_mask),
    .wr_data_i(s1_data),
    .rd_addr_i(s1_addr),
    .rd_data_o(rd_data)
  );

  sram_outreg #(.DW(DW)) i_out (
    .clk_i, .rst_ni,
    .s1_op_i(s1_op),
    .rd_data_i(rd_data),
    .oe_ni, .sleep_i, .q_o, .drive_o
  );
endmodule

// File: tb/test_pipe_sram.sv
`timescale 1ns/1ps
module test_pipe_sram;
  localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic gw_n = 1'b1, bw_n = 1'b1, oe_n = 1'b0, slp = 1'b0;
  logic [LN-1:0] we_n = '1;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] q;
  logic drv;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mem_m [1<<AW];

  logic p1_rd = 1'b0, p2_rd = 1'b0;
  logic [DW-1:0] p1_dat = '0, p2_dat = '0;
  string p1_tag = "R10", p2_tag = "R10";

  always #2.5 clk = ~clk;

  pipe_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_pipe_sram (
    .clk_i(clk), .rst_ni, .addr_i(addr), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .gw_ni(gw_n), .bw_ni(bw_n), .we_ni(we_n), .oe_ni(oe_n), .sleep_i(slp),
    .d_i(d), .q_o(q), .drive_o(drv)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [LN-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LN; i++) if (m[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic check_slot();
    logic exp_drv;
    string t;
    exp_drv = p2_rd && !oe_n && !slp;
    t = slp ? "R7" : ((p2_rd && oe_n) ? "R6" : p2_tag);
    check(drv === exp_drv, t, {35'd0, drv}, {35'd0, exp_drv});
    if (p2_rd) check(q === p2_dat, p2_tag, q, p2_dat);
  endtask

  task automatic step(input logic [AW-1:0] a, input logic c1n, input logic c2, input logic c3n,
                      input logic gwn, input logic bwn, input logic [LN-1:0] wen,
                      input logic oen, input logic zz, input logic [DW-1:0] wd, input string tag);
    logic sel, wr;
    logic [LN-1:0] m;
    @(negedge clk);
    check_slot();
    sel = !c1n && c2 && !c3n && !zz;
    m   = !gwn ? '1 : (!bwn ? ~wen : '0);
    wr  = sel && (m != '0);
    if (wr) mem_m[a] = merge(mem_m[a], wd, m);
    p2_rd = p1_rd; p2_dat = p1_dat; p2_tag = p1_tag;
    p1_rd = sel && !wr;
    p1_dat = mem_m[a];
    p1_tag = p1_rd ? tag : (zz ? "R7" : (!sel ? "R5" : "R8"));
    addr = a; ce1_n = c1n; ce2 = c2; ce3_n = c3n; gw_n = gwn; bw_n = bwn;
    we_n = wen; oe_n = oen; slp = zz; d = wd;
  endtask

  task automatic wr_full(input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
    step(a, 0, 1, 0, 0, 1, '1, 0, 0, wd, tag);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(a, 0, 1, 0, 1, 1, '1, 0, 0, '0, tag);
  endtask
  task automatic idle();
    step('0, 1, 1, 0, 1, 1, '1, 0, 0, '0, "R5");
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom} & {DW{1'b1}};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(drv === 1'b0, "R10", {35'd0, drv}, '0);

    // fill the model-tracked range
    for (int i = 0; i < 16; i++) wr_full(i[AW-1:0], rnd_word(), "R2");

    // full-word write, then lane writes
    wr_full(5, 36'h1_2345_6789, "R2");
    rd(5, "R2");
    step(5, 0, 1, 0, 1, 0, 4'b1010, 0, 0, 36'hF_EDCB_A987, "R3");
    rd(5, "R3");
    // both strobes inactive and bw active with no lane: reads only
    step(5, 0, 1, 0, 1, 1, 4'b0000, 0, 0, 36'h0_0000_0000, "R4");
    step(5, 0, 1, 0, 1, 0, 4'b1111, 0, 0, 36'h0_0000_0000, "R4");
    rd(5, "R4");
    // parity bits
    wr_full(6, {4{9'h1A5}}, "R9");
    rd(6, "R9");
    step(6, 0, 1, 0, 1, 0, 4'b0110, 0, 0, {4{9'h100}}, "R9");
    rd(6, "R9");

    // deselected writes are dropped, deselected reads do not drive
    step(7, 0, 0, 0, 0, 1, '1, 0, 0, 36'h0_DEAD_BEEF, "R5");
    step(7, 1, 1, 0, 0, 1, '1, 0, 0, 36'h0_DEAD_BEEF, "R5");
    step(7, 0, 1, 1, 0, 1, '1, 0, 0, 36'h0_DEAD_BEEF, "R5");
    rd(7, "R5");
    step(7, 0, 1, 1, 1, 1, '1, 0, 0, '0, "R5");
    idle(); idle();

    // asynchronous output enable
    rd(8, "R1"); idle(); idle();
    #0.5 oe_n = 1'b1;
    #0.5 check(drv === 1'b0, "R6", {35'd0, drv}, '0);
    oe_n = 1'b0;
    #0.5 check(drv === 1'b1, "R6", {35'd0, drv}, 36'd1);

    // sleep: no accept, retention
    wr_full(3, 36'h5_A5A5_A5A5, "R7");
    step(3, 0, 1, 0, 0, 1, '1, 0, 1, 36'h0_1111_1111, "R7");
    step(3, 0, 1, 0, 1, 1, '1, 0, 1, '0, "R7");
    step(3, 0, 1, 0, 1, 1, '1, 0, 1, '0, "R7");
    rd(3, "R7");
    idle(); idle();

    // write then immediate read: one-cycle pipeline
    wr_full(9, 36'h3_0F0F_0F0F, "R1");
    rd(9, "R1");
    rd(9, "R1");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      step($urandom % 16, ($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0,
           ($urandom % 4) != 0, ($urandom % 2) == 1, 4'($urandom), ($urandom % 8) == 0,
           ($urandom % 16) == 0, rnd_word(), "R1");
    end
    idle(); idle(); idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule